// File: doc/BRIEF.md
# Symmetric Up-Down PWM Generator with Per-Event Action Tables

The block makes two pulse-width-modulated outputs, A and B, from one triangular time base. A prescaler divides the system clock into counting ticks. On each tick the counter steps one count toward the programmed period, turns round there, and steps back down to zero. Two compare values are written into holding registers at any time. They become active only when the counter passes through zero, so a pulse width never changes in the middle of a triangle.

Each output has its own 12-bit action table with six 2-bit entries, one per counter event: counter at zero, counter at period, compare A matched while rising or while falling, and compare B matched while rising or while falling. An entry can leave the output alone, drive it low, drive it high, or invert it. A fixed priority decides between events that land on the same tick. An interrupt stage counts a selected counter event and raises a sticky flag on every Nth occurrence. Software clears the flag with a one-cycle clear pulse.

Top module: `pwm_updown_aq`

## Requirements
- R1: Synchronous active-low reset clears the counter to 0, sets the direction to rising, drives both outputs and the interrupt flag low, and zeroes the held and active compare values.
- R2: With period P > 0, successive ticks take the counter 0,1,…,P,P-1,…,1,0,1,… The direction flag turns to falling on the tick that leaves P, and back to rising on the tick that leaves 0.
- R3: With prescale value D, a tick occurs once every D+1 clocks. The counter holds its value on clocks without a tick.
- R4: A compare value written through its write strobe takes part in matching only from the first tick at count 0 that follows the write. Until then the previous active value is used.
- R5: Action entry codes are 00 none, 01 drive low, 10 drive high, 11 invert. The entry for an event sits at bits [2i+1:2i] of the table, with i = 0 zero, 1 period, 2 compare A rising, 3 compare A falling, 4 compare B rising, 5 compare B falling. An output changes on the clock edge of the tick that raised the event.
- R6: A compare match counts as rising while the direction flag is rising, and that includes the count equal to P. It counts as falling otherwise, and that includes the count 0 reached on the way down, except for the very first count 0 after reset, which counts as rising.
- R7: When several events with non-none entries fall on one tick, the entry used is the first in the order zero, period, compare A rising, compare B rising, compare A falling, compare B falling.
- R8: The interrupt source selector takes 0 for zero events, 1 for period events, 2 for both and 3 for none. The flag rises on every Nth selected event, N being the programmed count. N = 0 never raises the flag.
- R9: The interrupt flag stays high until a clear pulse. If a new interrupt is raised in the same cycle as a clear, the flag stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prescale | input | PRE_W | Tick divider; one tick every prescale+1 clocks |
| period | input | CNT_W | Turn-round count of the triangle |
| cmpa_wr | input | 1 | Write strobe for the compare A holding register |
| cmpa_data | input | CNT_W | New compare A value |
| cmpb_wr | input | 1 | Write strobe for the compare B holding register |
| cmpb_data | input | CNT_W | New compare B value |
| act_a | input | 2*NUM_EVT | Action table for output A |
| act_b | input | 2*NUM_EVT | Action table for output B |
| irq_sel | input | 2 | Interrupt source selector |
| irq_every | input | EVT_W | Number of selected events per interrupt |
| irq_clr | input | 1 | Clear pulse for the interrupt flag |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| irq | output | 1 | Sticky interrupt flag |
| tb_count | output | CNT_W | Present time-base count |
| count_up | output | 1 | Direction flag, 1 while rising |

## Verification
Two pairs of events can fall on the same tick and need checking. The first pair is the counter reaching zero while a compare register is also zero. With compare values left at reset, a toggle on the zero event competes with a drive-low on a falling compare B match, and a drive-high on a rising compare A match competes with a drive-low on a rising compare B match. The outputs are compared tick by tick against the priority order. The second pair is the interrupt and its clear. The clear pulse is placed on the exact edge on which the third zero event raises the flag, and the flag is expected to stay high there and fall one edge later.

// File: rtl/pwm_aq_pkg.sv
// Package: shared event indices, action codes and interrupt selector codes
// for the up-down PWM generator. Assumes six events per action table.
package pwm_aq_pkg;

    localparam int NUM_EVT = 6;

    // Event index; also the entry position in an action table.
    localparam int EVT_ZERO = 0;
    localparam int EVT_PRD  = 1;
    localparam int EVT_CAU  = 2;
    localparam int EVT_CAD  = 3;
    localparam int EVT_CBU  = 4;
    localparam int EVT_CBD  = 5;

    // Events from highest to lowest priority.
    localparam int PRIO_ORDER [NUM_EVT] = '{EVT_ZERO, EVT_PRD, EVT_CAU,
                                            EVT_CBU, EVT_CAD, EVT_CBD};

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_CLR  = 2'b01,
        ACT_SET  = 2'b10,
        ACT_TGL  = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        TRIG_ZERO = 2'd0,
        TRIG_PRD  = 2'd1,
        TRIG_BOTH = 2'd2,
        TRIG_OFF  = 2'd3
    } trig_sel_e;

endpackage

// File: rtl/pwm_timebase.sv
// Time base: a prescaler makes counting ticks, and a triangular counter
// climbs to the period and falls back to zero, one step per tick.
// Assumes the period is held steady while the counter is running.
module pwm_timebase #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] prescale,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_up,
    output logic             tick
);

    logic [PRE_W-1:0] pre_q;

    assign tick = (pre_q >= prescale);

    // Prescaler: wraps to zero on the clock that issues a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + 1'b1;
    end

    // Triangle counter with direction flag, advancing only on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            dir_up <= 1'b1;
        end else if (tick) begin
            if (period == '0) begin
                cnt    <= '0;
                dir_up <= 1'b1;
            end else if (dir_up) begin
                if (cnt >= period) begin
                    cnt    <= cnt - 1'b1;
                    dir_up <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                if (cnt == '0) begin
                    cnt    <= cnt + 1'b1;
                    dir_up <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));                                            // R3
    AST_TURN_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && dir_up && cnt == period && period != '0) |=> !dir_up);    // R2
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && period != '0 && cnt <= period) |=>
        (cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1));           // R2

endmodule

// File: rtl/pwm_cmp_shadow.sv
// Double-buffered compare value: software writes the holding register at
// any time, and the active register copies it on the load strobe only.
// Assumes load is the tick at count zero.
module pwm_cmp_shadow #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             load,
    output logic [CNT_W-1:0] active
);

    logic [CNT_W-1:0] hold_q;

    // Holding register: captures every software write.
    always_ff @(posedge clk) begin
        if (!rst_n)     hold_q <= '0;
        else if (wr_en) hold_q <= wr_data;
    end

    // Active register: refreshed from the holding register at count zero.
    always_ff @(posedge clk) begin
        if (!rst_n)    active <= '0;
        else if (load) active <= hold_q;
    end

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(active));                                         // R4

endmodule

// File: rtl/pwm_action_qual.sv
// Action qualifier for one output: among the events raised on this tick,
// the highest-priority one with a non-none entry decides the next level.
// Assumes event strobes last one clock each.
module pwm_action_qual
    import pwm_aq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_EVT-1:0]   evt,
    input  logic [2*NUM_EVT-1:0] act_tbl,
    output logic                 out
);

    act_e pick;

    // Priority pick: scan from lowest to highest so the highest wins.
    always_comb begin
        pick = ACT_NONE;
        for (int i = NUM_EVT - 1; i >= 0; i--) begin
            if (evt[PRIO_ORDER[i]] &&
                act_e'(act_tbl[2*PRIO_ORDER[i] +: 2]) != ACT_NONE)
                pick = act_e'(act_tbl[2*PRIO_ORDER[i] +: 2]);
        end
    end

    // Output register: applies the chosen action.
    always_ff @(posedge clk) begin
        if (!rst_n) out <= 1'b0;
        else begin
            case (pick)
                ACT_CLR:  out <= 1'b0;
                ACT_SET:  out <= 1'b1;
                ACT_TGL:  out <= ~out;
                default:  out <= out;
            endcase
        end
    end

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == '0) |=> $stable(out));                                      // R5
    AST_ZERO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[EVT_ZERO] && act_tbl[2*EVT_ZERO +: 2] == 2'b10) |=> out);     // R7

endmodule

// File: rtl/pwm_evt_trig.sv
// Interrupt stage: counts the selected counter events and raises a sticky
// flag on every Nth one. Assumes the clear is a pulse from software.
module pwm_evt_trig
    import pwm_aq_pkg::*;
#(
    parameter int EVT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_zero,
    input  logic             ev_prd,
    input  logic [1:0]       sel,
    input  logic [EVT_W-1:0] every,
    input  logic             clr,
    output logic             irq
);

    logic [EVT_W-1:0] seen_q;
    logic [EVT_W:0]   seen_nxt;
    logic             sel_ev;
    logic             fire;

    // Source selection.
    always_comb begin
        case (trig_sel_e'(sel))
            TRIG_ZERO: sel_ev = ev_zero;
            TRIG_PRD:  sel_ev = ev_prd;
            TRIG_BOTH: sel_ev = ev_zero | ev_prd;
            default:   sel_ev = 1'b0;
        endcase
    end

    assign seen_nxt = {1'b0, seen_q} + 1'b1;
    assign fire     = sel_ev && (every != '0) && (seen_nxt >= {1'b0, every});

    // Occurrence counter: restarts after each interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)      seen_q <= '0;
        else if (fire)   seen_q <= '0;
        else if (sel_ev && every != '0) seen_q <= seen_nxt[EVT_W-1:0];
    end

    // Sticky flag: a new interrupt outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    irq <= 1'b0;
        else if (fire) irq <= 1'b1;
        else if (clr)  irq <= 1'b0;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq);                                             // R9
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !sel_ev) |=> !irq);                                        // R8

endmodule

// File: rtl/pwm_updown_aq.sv
// Top: up-down time base, two double-buffered compares, event decode,
// two action-qualified outputs and an interrupt stage.
// Assumes one clock domain and software writes as single-cycle strobes.
module pwm_updown_aq
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8,
    parameter int EVT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PRE_W-1:0]     prescale,
    input  logic [CNT_W-1:0]     period,
    input  logic                 cmpa_wr,
    input  logic [CNT_W-1:0]     cmpa_data,
    input  logic                 cmpb_wr,
    input  logic [CNT_W-1:0]     cmpb_data,
    input  logic [2*NUM_EVT-1:0] act_a,
    input  logic [2*NUM_EVT-1:0] act_b,
    input  logic [1:0]           irq_sel,
    input  logic [EVT_W-1:0]     irq_every,
    input  logic                 irq_clr,
    output logic                 pwm_a,
    output logic                 pwm_b,
    output logic                 irq,
    output logic [CNT_W-1:0]     tb_count,
    output logic                 count_up
);

    localparam int N_CH  = 2;
    localparam int TBL_W = 2 * NUM_EVT;

    logic                          tick;
    logic [CNT_W-1:0]              cnt;
    logic                          dir_up;
    logic [NUM_EVT-1:0]            evt;
    logic [N_CH-1:0]               cmp_wr;
    logic [N_CH-1:0][CNT_W-1:0]    cmp_wdat;
    logic [N_CH-1:0][CNT_W-1:0]    cmp_act;
    logic [N_CH-1:0][TBL_W-1:0]    tbl;
    logic [N_CH-1:0]               pwm_q;

    pwm_timebase #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .prescale(prescale), .period(period),
        .cnt(cnt), .dir_up(dir_up), .tick(tick)
    );

    assign cmp_wr   = {cmpb_wr, cmpa_wr};
    assign cmp_wdat = {cmpb_data, cmpa_data};
    assign tbl      = {act_b, act_a};

    // One double-buffered compare per channel, loaded at count zero.
    for (genvar c = 0; c < N_CH; c++) begin : g_cmp
        pwm_cmp_shadow #(.CNT_W(CNT_W)) u_cmp (
            .clk(clk), .rst_n(rst_n), .wr_en(cmp_wr[c]), .wr_data(cmp_wdat[c]),
            .load(evt[EVT_ZERO]), .active(cmp_act[c])
        );
    end

    // Event decode: every event is qualified by a tick.
    always_comb begin
        evt           = '0;
        evt[EVT_ZERO] = tick && (cnt == '0);
        evt[EVT_PRD]  = tick && (cnt == period);
        evt[EVT_CAU]  = tick &&  dir_up && (cnt == cmp_act[0]);
        evt[EVT_CAD]  = tick && !dir_up && (cnt == cmp_act[0]);
        evt[EVT_CBU]  = tick &&  dir_up && (cnt == cmp_act[1]);
        evt[EVT_CBD]  = tick && !dir_up && (cnt == cmp_act[1]);
    end

    // One action qualifier per output, each with its own table.
    for (genvar c = 0; c < N_CH; c++) begin : g_out
        pwm_action_qual u_aq (
            .clk(clk), .rst_n(rst_n), .evt(evt), .act_tbl(tbl[c]), .out(pwm_q[c])
        );
    end

    pwm_evt_trig #(.EVT_W(EVT_W)) u_trig (
        .clk(clk), .rst_n(rst_n), .ev_zero(evt[EVT_ZERO]), .ev_prd(evt[EVT_PRD]),
        .sel(irq_sel), .every(irq_every), .clr(irq_clr), .irq(irq)
    );

    assign pwm_a    = pwm_q[0];
    assign pwm_b    = pwm_q[1];
    assign tb_count = cnt;
    assign count_up = dir_up;

endmodule

// File: tb/tb_pwm_updown_aq.sv
`timescale 1ns/1ps
module tb_pwm_updown_aq;

    localparam int CNT_W = 16;
    localparam int PRE_W = 8;
    localparam int EVT_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PRE_W-1:0]  prescale = '0;
    logic [CNT_W-1:0]  period = '0;
    logic              cmpa_wr = 1'b0;
    logic [CNT_W-1:0]  cmpa_data = '0;
    logic              cmpb_wr = 1'b0;
    logic [CNT_W-1:0]  cmpb_data = '0;
    logic [11:0]       act_a = '0;
    logic [11:0]       act_b = '0;
    logic [1:0]        irq_sel = 2'd3;
    logic [EVT_W-1:0]  irq_every = '0;
    logic              irq_clr = 1'b0;
    logic              pwm_a, pwm_b, irq, count_up;
    logic [CNT_W-1:0]  tb_count;

    pwm_updown_aq #(.CNT_W(CNT_W), .PRE_W(PRE_W), .EVT_W(EVT_W)) dut (
        .clk(clk), .rst_n(rst_n), .prescale(prescale), .period(period),
        .cmpa_wr(cmpa_wr), .cmpa_data(cmpa_data), .cmpb_wr(cmpb_wr),
        .cmpb_data(cmpb_data), .act_a(act_a), .act_b(act_b),
        .irq_sel(irq_sel), .irq_every(irq_every), .irq_clr(irq_clr),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .irq(irq), .tb_count(tb_count),
        .count_up(count_up)
    );

    always #2 clk = ~clk;   // 250 MHz

    typedef struct {
        int    k;
        int    sig;     // 0 count, 1 pwm_a, 2 pwm_b, 3 irq
        int    val;
        string req;
    } item_t;

    item_t sbq[$];
    int    kc = 0;
    int    n_chk = 0;
    int    n_fail = 0;

    // Edge counter since reset release.
    always @(posedge clk) kc <= rst_n ? kc + 1 : 0;

    task automatic check(int got, int exp, string req, string what);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic push(int k, int sig, int val, string req);
        item_t it;
        it.k = k; it.sig = sig; it.val = val; it.req = req;
        sbq.push_back(it);
    endtask

    function automatic int tri_val(int j, int p);
        int m;
        m = j % (2 * p);
        return (m <= p) ? m : 2 * p - m;
    endfunction

    // Monitor: pops expected items whose edge count has arrived.
    always @(negedge clk) begin
        if (rst_n) begin
            while (sbq.size() > 0 && sbq[0].k == kc) begin
                item_t it;
                int    got;
                it = sbq.pop_front();
                case (it.sig)
                    0:       got = int'(tb_count);
                    1:       got = int'(pwm_a);
                    2:       got = int'(pwm_b);
                    default: got = int'(irq);
                endcase
                check(got, it.val, it.req, $sformatf("sig%0d at edge %0d", it.sig, it.k));
            end
        end
    end

    task automatic wait_k(int n);
        while (kc != n) @(negedge clk);
    endtask

    task automatic drain();
        while (sbq.size() > 0) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // Phase 1: reset state, then main triangle with shadow and interrupt.
        prescale  = 0;
        period    = 8;
        act_a     = 12'h408;   // period: drive high; compare B falling: drive low
        act_b     = 12'h024;   // period: drive low; compare A rising: drive high
        irq_sel   = 2'd0;
        irq_every = 3;
        repeat (3) @(negedge clk);
        check(int'(tb_count), 0, "R1", "count in reset");
        check(int'(count_up), 1, "R1", "direction in reset");
        check(int'(pwm_a), 0, "R1", "pwm_a in reset");
        check(int'(pwm_b), 0, "R1", "pwm_b in reset");
        check(int'(irq), 0, "R1", "irq in reset");

        for (int k = 17; k <= 90; k++) begin
            int m, ca;
            m  = k % 16;
            ca = (k <= 32) ? 2 : 5;
            push(k, 0, tri_val(k, 8), "R2");
            push(k, 1, (m >= 9 && m <= 14) ? 1 : 0, "R6");
            push(k, 2, (m >= ca + 1 && m <= 8) ? 1 : 0, (k <= 48) ? "R4" : "R5");
            push(k, 3, ((k >= 33 && k <= 40) || k >= 81) ? 1 : 0,
                 (k >= 41 && k <= 80) ? "R9" : "R8");
        end
        rst_n = 1'b1;
        wait_k(1);
        cmpa_wr = 1'b1; cmpa_data = 2;
        cmpb_wr = 1'b1; cmpb_data = 2;
        @(negedge clk);
        cmpa_wr = 1'b0; cmpb_wr = 1'b0;
        wait_k(17);
        cmpa_wr = 1'b1; cmpa_data = 5;
        @(negedge clk);
        cmpa_wr = 1'b0;
        wait_k(40);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        drain();

        // Phase 2: prescaler and period-selected interrupt.
        rst_n     = 1'b0;
        prescale  = 2;
        period    = 3;
        act_a     = '0;
        act_b     = '0;
        irq_sel   = 2'd1;
        irq_every = 1;
        repeat (2) @(negedge clk);
        for (int k = 1; k <= 40; k++) begin
            push(k, 0, tri_val(k / 3, 3), "R3");
            if (k == 11) push(k, 3, 0, "R8");
            if (k == 12 || k == 30) push(k, 3, 1, "R8");
        end
        rst_n = 1'b1;
        drain();

        // Phase 3: coincident events and interrupt raised during a clear.
        rst_n     = 1'b0;
        prescale  = 0;
        period    = 4;
        act_a     = 12'h403;   // zero: invert; compare B falling: drive low
        act_b     = 12'h124;   // period low; compare A rising high; compare B rising low
        irq_sel   = 2'd0;
        irq_every = 3;
        repeat (2) @(negedge clk);
        for (int k = 1; k <= 30; k++) begin
            push(k, 1, (((k - 1) / 8) % 2 == 0) ? 1 : 0, "R7");
            push(k, 2, (k <= 4) ? 1 : 0, "R7");
            if (k == 16) push(k, 3, 0, "R8");
            if (k == 17) push(k, 3, 1, "R9");
            if (k == 18) push(k, 3, 0, "R9");
        end
        rst_n = 1'b1;
        wait_k(16);
        irq_clr = 1'b1;
        wait_k(18);
        irq_clr = 1'b0;
        drain();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule